// File: doc/BRIEF.md
# Two-Wire Bus Controller Status Flags

This block keeps the one-byte status word of a two-wire serial bus controller that can act as bus master or as slave. It samples the raw clock and data lines through a synchroniser and finds start and stop conditions on them. It also counts clock pulses within each byte, so that a start or stop arriving in the middle of a byte is reported as a bus error. The byte engine next to it reports its events as single-cycle strobes: arbitration won or lost, own-address or general-call match, byte complete (with the acknowledge result), and address phase complete. Those strobes set event flags and mode bits here.

Software reads the status word as `status_o`. It clears event flags by writing ones on the write port, and writing zeros there changes nothing. When the stall option is on and a master address phase ends cleanly, the block raises a stall flag. While that flag is set and the controller is master, the block asks for the clock line to be held low. An interrupt line reports a new address match or a pending stall when interrupts are enabled.

Top module: `i2c_stat_unit`

## Requirements
- R1: After reset, all eight status bits are 0. The layout is fixed from bit 7 down to bit 0: slave-stop, data-ready, bus-error, negative-ack, stall, new-match, master, transmit.
- R2: While `enable_i` is 0 or `lowpwr_i` is 1, the status word becomes 0 at the next clock edge. This clear overrides every set event in the same cycle.
- R3: A write with `wr_en_i` clears each of bits 7, 5, 4, 3 and 2 whose `wr_data_i` bit is 1. Zero bits leave the flag unchanged. Writes have no effect on bits 6, 1 and 0. A set event in the same cycle wins over the clear.
- R4: After synchronisation, a start (data falls while clock is high) or a stop (data rises while clock is high) sets bus-error when the in-byte clock count is between 2 and 9. The count is 0 after a start or stop, counts clock rising edges from 1 to 9, and wraps from 9 to 1. A condition at count 0 or 1 does not set bus-error.
- R5: `arb_won_i` sets master. `arb_lost_i` clears master and sets bus-error. A stop condition clears master.
- R6: `byte_done_i` with `nack_i`=1 while `xmit_i`=1 sets negative-ack and leaves data-ready unset. `byte_done_i` with `nack_i`=0 sets data-ready. `data_access_i` clears data-ready.
- R7: `addr_done_i` sets the stall flag only when `stall_en_i`=1, master=1, bus-error=0, negative-ack=0 and `nack_i`=0. `scl_stall_o` is high exactly while the stall flag and master are both 1.
- R8: `addr_match_i` sets new-match.
- R9: `irq_o` equals `int_en_i` AND (new-match OR stall).
- R10: The transmit bit takes the value of `xmit_i` one cycle later.
- R11: A stop condition seen while master=0 and new-match=1 sets slave-stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Module enable; 0 clears status |
| lowpwr_i | input | 1 | Halt/idle power state; 1 clears status |
| scl_i | input | 1 | Raw clock line level |
| sda_i | input | 1 | Raw data line level |
| arb_won_i | input | 1 | Bus ownership request succeeded |
| arb_lost_i | input | 1 | Arbitration lost |
| addr_match_i | input | 1 | Address byte matched own or general-call address |
| byte_done_i | input | 1 | Byte with acknowledge slot completed |
| nack_i | input | 1 | Acknowledge slot was not acknowledged (qualifies strobes) |
| addr_done_i | input | 1 | Master address phase completed |
| xmit_i | input | 1 | Engine is in a transmit mode |
| data_access_i | input | 1 | Software accessed the data byte |
| stall_en_i | input | 1 | Stall after address phase enabled |
| int_en_i | input | 1 | Interrupt enable |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 8 | Write-one-to-clear mask |
| status_o | output | 8 | Status word |
| scl_stall_o | output | 1 | Request to hold the clock line low |
| irq_o | output | 1 | Interrupt request |

## Verification
Random strobe and write traffic runs with the bus lines idle, so every flag update comes from engine events and software clears alone. A bench model predicts each cycle, which separates set-versus-clear priority, the qualifiers of the stall condition and the gating of negative-ack by transmit mode. Directed line waveforms then place start and stop conditions at counts 0, 1, 4 and 9. These show where the error window begins and ends, that the count wraps after the acknowledge slot, and that a stop alone, without an error, clears master and reports slave-stop.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
   localparam int STAT_W  = 8;
   localparam int B_XMIT  = 0;
   localparam int B_MSTR  = 1;
   localparam int B_NMAT  = 2;
   localparam int B_STALL = 3;
   localparam int B_NACK  = 4;
   localparam int B_BERR  = 5;
   localparam int B_DRDY  = 6;
   localparam int B_SSTOP = 7;
   localparam logic [STAT_W-1:0] W1C_MASK = 8'b1011_1100;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic scl_prev, sda_prev;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_sh[i] <= 1'b1;
            sda_sh[i] <= 1'b1;
         end else if (i == 0) begin
            scl_sh[i] <= scl_i;
            sda_sh[i] <= sda_i;
         end else begin
            scl_sh[i] <= scl_sh[i-1];
            sda_sh[i] <= sda_sh[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_sh[SYNC_STAGES-1];
         sda_prev <= sda_sh[SYNC_STAGES-1];
      end
   end

   wire scl_s = scl_sh[SYNC_STAGES-1];
   wire sda_s = sda_sh[SYNC_STAGES-1];

   assign start_o    = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_o     = scl_s & scl_prev & ~sda_prev & sda_s;
   assign scl_rise_o = scl_s & ~scl_prev;

   a_r4_no_dual_cond: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_o && stop_o));
endmodule

// File: rtl/i2c_bit_window.sv
module i2c_bit_window #(
   parameter int FRAME_BITS    = 9,
   parameter int ERR_FIRST_BIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic start_i,
   input  logic stop_i,
   input  logic scl_rise_i,
   output logic cond_err_o
);
   localparam int CNT_W = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(ERR_FIRST_BIT);

   if (ERR_FIRST_BIT < 1 || ERR_FIRST_BIT > FRAME_BITS) begin : g_bad_win
      $error("ERR_FIRST_BIT out of range");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!enable_i)        cnt_q <= '0;
      else if (start_i || stop_i) cnt_q <= '0;
      else if (scl_rise_i)       cnt_q <= (cnt_q == CNT_LAST) ? CNT_W'(1) : cnt_q + CNT_W'(1);
   end

   assign cond_err_o = (start_i | stop_i) & (cnt_q >= CNT_FIRST);

   a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST);
   a_r4_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i || stop_i) |=> cnt_q == '0);
endmodule

// File: rtl/i2c_stat_unit.sv
module i2c_stat_unit #(
   parameter int SYNC_STAGES   = 2,
   parameter int FRAME_BITS    = 9,
   parameter int ERR_FIRST_BIT = 2,
   parameter bit IRQ_REG       = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable_i,
   input  logic       lowpwr_i,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       arb_won_i,
   input  logic       arb_lost_i,
   input  logic       addr_match_i,
   input  logic       byte_done_i,
   input  logic       nack_i,
   input  logic       addr_done_i,
   input  logic       xmit_i,
   input  logic       data_access_i,
   input  logic       stall_en_i,
   input  logic       int_en_i,
   input  logic       wr_en_i,
   input  logic [7:0] wr_data_i,
   output logic [7:0] status_o,
   output logic       scl_stall_o,
   output logic       irq_o
);
   import i2c_stat_pkg::*;

   logic start_det, stop_det, scl_rise, cond_err;
   logic [STAT_W-1:0] stat_q, stat_d;
   logic active;

   i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .start_o(start_det), .stop_o(stop_det), .scl_rise_o(scl_rise));

   i2c_bit_window #(.FRAME_BITS(FRAME_BITS), .ERR_FIRST_BIT(ERR_FIRST_BIT)) u_win (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .start_i(start_det),
      .stop_i(stop_det), .scl_rise_i(scl_rise), .cond_err_o(cond_err));

   assign active = enable_i & ~lowpwr_i;

   always_comb begin
      stat_d = stat_q;
      if (wr_en_i) stat_d = stat_d & ~(wr_data_i & W1C_MASK);
      stat_d[B_XMIT] = xmit_i;
      if (arb_won_i) stat_d[B_MSTR] = 1'b1;
      if (stop_det) begin
         stat_d[B_MSTR] = 1'b0;
         if (!stat_q[B_MSTR] && stat_q[B_NMAT]) stat_d[B_SSTOP] = 1'b1;
      end
      if (arb_lost_i) begin
         stat_d[B_MSTR] = 1'b0;
         stat_d[B_BERR] = 1'b1;
      end
      if (cond_err) stat_d[B_BERR] = 1'b1;
      if (data_access_i) stat_d[B_DRDY] = 1'b0;
      if (byte_done_i) begin
         if (nack_i) begin
            if (xmit_i) stat_d[B_NACK] = 1'b1;
         end else begin
            stat_d[B_DRDY] = 1'b1;
         end
      end
      if (addr_match_i) stat_d[B_NMAT] = 1'b1;
      if (addr_done_i && stall_en_i && stat_q[B_MSTR] && !stat_q[B_BERR]
          && !stat_q[B_NACK] && !nack_i) stat_d[B_STALL] = 1'b1;
      if (!active) stat_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assign status_o    = stat_q;
   assign scl_stall_o = stat_q[B_STALL] & stat_q[B_MSTR];

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= int_en_i & (stat_q[B_NMAT] | stat_q[B_STALL]);
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = int_en_i & (stat_q[B_NMAT] | stat_q[B_STALL]);
   end

   a_r2_inactive_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> stat_q == '0);
   a_r3_w1c_nmatch: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_data_i[B_NMAT] && !addr_match_i) |=> !stat_q[B_NMAT]);
   a_r4_window_err: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cond_err) |=> stat_q[B_BERR]);
   a_r5_stop_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !stat_q[B_MSTR]);
   a_r6_nack_no_drdy: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done_i && nack_i && !stat_q[B_DRDY]) |=> !stat_q[B_DRDY]);
   a_r8_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (active && addr_match_i) |=> stat_q[B_NMAT]);
endmodule

// File: tb/i2c_stat_unit_tb.sv
module i2c_stat_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int XB = 0, MB = 1, NMB = 2, STB = 3, NKB = 4, BEB = 5, DRB = 6, SSB = 7;

   logic clk = 0, rst_n = 0;
   logic enable_i = 0, lowpwr_i = 0, scl_i = 1, sda_i = 1;
   logic arb_won_i = 0, arb_lost_i = 0, addr_match_i = 0, byte_done_i = 0, nack_i = 0;
   logic addr_done_i = 0, xmit_i = 0, data_access_i = 0, stall_en_i = 0, int_en_i = 0;
   logic wr_en_i = 0;
   logic [7:0] wr_data_i = 0;
   logic [7:0] status_o;
   logic scl_stall_o, irq_o;
   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_stat_unit u_dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] model(input logic [7:0] s);
      logic [7:0] n = s;
      if (!enable_i || lowpwr_i) return 8'h00;
      if (wr_en_i) n = n & ~(wr_data_i & 8'hBC);
      n[XB] = xmit_i;
      if (arb_won_i) n[MB] = 1;
      if (arb_lost_i) begin n[MB] = 0; n[BEB] = 1; end
      if (data_access_i) n[DRB] = 0;
      if (byte_done_i && nack_i && xmit_i) n[NKB] = 1;
      if (byte_done_i && !nack_i) n[DRB] = 1;
      if (addr_match_i) n[NMB] = 1;
      if (addr_done_i && stall_en_i && s[MB] && !s[BEB] && !s[NKB] && !nack_i) n[STB] = 1;
      return n;
   endfunction

   task automatic idle_all();
      arb_won_i = 0; arb_lost_i = 0; addr_match_i = 0; byte_done_i = 0; nack_i = 0;
      addr_done_i = 0; data_access_i = 0; wr_en_i = 0; wr_data_i = 0;
   endtask

   task automatic bus(input logic c, input logic d);
      @(negedge clk); scl_i = c; sda_i = d;
      repeat (4) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] m);
      @(negedge clk); wr_en_i = 1; wr_data_i = m;
      @(negedge clk); wr_en_i = 0; wr_data_i = 0;
   endtask

   task automatic clk_pulses(input int n);
      for (int i = 0; i < n; i++) begin bus(0, 0); bus(1, 0); end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] exp;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk("R1 reset status", status_o, 8'h00);
      rst_n = 1; enable_i = 1;
      @(negedge clk);
      chk("R1 status after reset release", status_o, 8'h00);

      // random event traffic, bus idle
      exp = status_o;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         chk("R3 R5 R6 R7 R8 R10 status model", status_o, exp);
         chk("R9 irq", irq_o, int_en_i & (exp[NMB] | exp[STB]));
         chk("R7 stall output", scl_stall_o, exp[STB] & exp[MB]);
         enable_i      = ($urandom % 60) != 0;
         lowpwr_i      = ($urandom % 80) == 0;
         arb_won_i     = ($urandom % 8) == 0;
         arb_lost_i    = ($urandom % 16) == 0;
         addr_match_i  = ($urandom % 10) == 0;
         byte_done_i   = ($urandom % 6) == 0;
         nack_i        = ($urandom % 3) == 0;
         addr_done_i   = ($urandom % 5) == 0;
         xmit_i        = $urandom % 2;
         data_access_i = ($urandom % 7) == 0;
         stall_en_i    = ($urandom % 4) != 0;
         int_en_i      = $urandom % 2;
         wr_en_i       = ($urandom % 5) == 0;
         wr_data_i     = 8'($urandom);
         exp = model(exp);
      end
      @(negedge clk);
      idle_all(); lowpwr_i = 0; int_en_i = 0; stall_en_i = 0; xmit_i = 0; enable_i = 0;
      @(negedge clk);
      chk("R2 disable clears", status_o, 8'h00);
      enable_i = 1;

      // R4/R5: stop inside the byte at count 4
      @(negedge clk); arb_won_i = 1; @(negedge clk); arb_won_i = 0;
      chk("R5 master set", status_o[MB], 1);
      bus(1, 0);
      chk("R4 start at count 0 no error", status_o[BEB], 0);
      clk_pulses(4);
      bus(1, 1);
      chk("R4 stop at count 4 sets error", status_o[BEB], 1);
      chk("R5 stop clears master", status_o[MB], 0);
      wr(8'h20);
      chk("R3 w1c clears bus-error", status_o[BEB], 0);

      // R8/R3/R11
      @(negedge clk); addr_match_i = 1; @(negedge clk); addr_match_i = 0;
      chk("R8 new-match set", status_o[NMB], 1);
      wr(8'h00);
      chk("R3 writing zero keeps new-match", status_o[NMB], 1);
      wr(8'h43);
      chk("R3 non-w1c bits ignore writes", status_o, 8'h04);
      bus(1, 0);
      bus(1, 1);
      chk("R11 slave-stop set", status_o[SSB], 1);
      chk("R4 stop at count 0 no error", status_o[BEB], 0);
      wr(8'hFF);
      chk("R3 full clear", status_o, 8'h00);

      // R4 boundaries: count 9 in window, wrap to 1 outside
      bus(1, 0); clk_pulses(9); bus(1, 1);
      chk("R4 stop at count 9 sets error", status_o[BEB], 1);
      wr(8'h20);
      bus(1, 0); clk_pulses(10); bus(1, 1);
      chk("R4 stop after wrap to 1 no error", status_o[BEB], 0);
      bus(1, 0); clk_pulses(2); bus(1, 1);
      chk("R4 stop at count 2 sets error", status_o[BEB], 1);
      wr(8'hFF);

      // R7/R9 stall
      stall_en_i = 1; int_en_i = 1;
      @(negedge clk); arb_won_i = 1; @(negedge clk); arb_won_i = 0;
      @(negedge clk); addr_done_i = 1; @(negedge clk); addr_done_i = 0;
      chk("R7 stall flag set", status_o[STB], 1);
      chk("R7 stall output high", scl_stall_o, 1);
      chk("R9 irq on stall", irq_o, 1);
      wr(8'h08);
      chk("R7 stall released", scl_stall_o, 0);
      chk("R9 irq drops", irq_o, 0);
      @(negedge clk); arb_lost_i = 1; @(negedge clk); arb_lost_i = 0;
      chk("R5 arbitration loss", status_o[MB:MB] == 0 && status_o[BEB] == 1, 1);
      wr(8'h20);
      @(negedge clk); addr_done_i = 1; @(negedge clk); addr_done_i = 0;
      chk("R7 no stall in slave mode", status_o[STB], 0);
      int_en_i = 0;
      @(negedge clk); addr_match_i = 1; @(negedge clk); addr_match_i = 0;
      chk("R9 irq masked", irq_o, 0);

      // R6/R10
      xmit_i = 1;
      @(negedge clk); byte_done_i = 1; nack_i = 1; @(negedge clk); byte_done_i = 0; nack_i = 0;
      chk("R6 negative-ack set", status_o[NKB], 1);
      chk("R6 no data-ready on nack", status_o[DRB], 0);
      chk("R10 transmit bit", status_o[XB], 1);
      @(negedge clk); byte_done_i = 1; @(negedge clk); byte_done_i = 0;
      chk("R6 data-ready set", status_o[DRB], 1);
      @(negedge clk); data_access_i = 1; @(negedge clk); data_access_i = 0;
      chk("R6 data access clears data-ready", status_o[DRB], 0);
      lowpwr_i = 1; @(negedge clk); lowpwr_i = 0;
      chk("R2 low power clears", status_o, 8'h00);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule